// File: doc/BRIEF.md
# Instruction TLB LRU Tracker

This block keeps the least-recently-used order for a four-entry, fully associative instruction TLB. The order is packed as six pairwise "newer-than" flags in the top bits of a 32-bit MMU control register. Each flag records, for one pair of entries, which of the two was used more recently. A hit strobe with a 2-bit entry index moves that entry to the most-recent position. A refill strobe moves the current victim to the most-recent position, because a refill writes the victim entry.

The victim index is decoded combinationally from the registered state, so a refill controller can use it in the same cycle that it raises its request. Software can overwrite the whole control register through a load port. The register bits below the order field belong to other MMU functions. The tracker carries them along and never alters them.

Top module: `itlb_lru_tracker`

## Requirements
- R1: After reset the control register reads 0x00000000 and the victim index reads 3.
- R2: A software write loads all 32 bits of `sw_data` into the register on the next clock. It wins over a hit and over a refill in the same cycle.
- R3: A hit on entry 0 clears register bits 31, 30 and 29 and leaves the other order bits unchanged.
- R4: A hit on entry 1 clears bits 28 and 27, sets bit 31 and leaves the other order bits unchanged.
- R5: A hit on entry 2 clears bit 26, sets bits 30 and 28 and leaves the other order bits unchanged.
- R6: A hit on entry 3 sets bits 29, 27 and 26 and leaves the other order bits unchanged.
- R7: Hits and refills never change register bits 25:0.
- R8: The victim index depends only on the current register and is valid in the same cycle. The tests are made in this priority order: 0 when bits 31:29 are all one; otherwise 1 when bit 31 is 0 and bits 28 and 27 are 1; otherwise 2 when bits 30 and 28 are 0 and bit 26 is 1; otherwise 3.
- R9: A refill applies the update of the entry currently named by the victim index on the next clock. It takes priority over a hit in the same cycle.
- R10: With no write, hit or refill, the register holds its value.
- R11: Starting from reset, after any sequence of hits and refills the victim index names the entry touched least recently. An entry that was never touched counts as older than any touched entry, and the reset order from oldest to newest is 3, 2, 1, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr | input | 1 | Software load strobe for the control register |
| sw_data | input | 32 | Value loaded when `sw_wr` is high |
| hit_vld | input | 1 | A lookup hit an entry this cycle |
| hit_idx | input | 2 | Index of the entry that was hit |
| repl_req | input | 1 | A refill writes the victim entry this cycle |
| ctrl_q | output | 32 | Current control register value |
| victim_idx | output | 2 | Entry to replace, decoded from `ctrl_q` |

## Verification
A hit and a refill can arrive in the same cycle, and either can also coincide with a software load. The bench provokes both overlaps. One vector raises a hit on entry 3 together with a refill while entry 1 is the victim. The register must then show the entry 1 update, and the victim must move to 3. A directed cycle raises all three strobes at once, and the register must then equal the written word exactly.

// File: rtl/itlb_lru_pkg.sv
`timescale 1ns/1ps
package itlb_lru_pkg;

  localparam int unsigned WAYS     = 4;
  localparam int unsigned ORDER_W  = WAYS * (WAYS - 1) / 2;
  localparam int unsigned IDX_W    = $clog2(WAYS);

  typedef logic [ORDER_W-1:0] order_t;
  typedef logic [IDX_W-1:0]   way_t;

  // Pair flags, MSB first: [5]=1>0 [4]=2>0 [3]=3>0 [2]=2>1 [1]=3>1 [0]=3>2
  // (a>b means a was used more recently than b).

  function automatic order_t keep_mask(way_t w);
    case (w)
      2'd0:    keep_mask = 6'b000111;
      2'd1:    keep_mask = 6'b111001;
      2'd2:    keep_mask = 6'b111110;
      default: keep_mask = 6'b111111;
    endcase
  endfunction

  function automatic order_t set_mask(way_t w);
    case (w)
      2'd0:    set_mask = 6'b000000;
      2'd1:    set_mask = 6'b100000;
      2'd2:    set_mask = 6'b010100;
      default: set_mask = 6'b001011;
    endcase
  endfunction

  function automatic order_t order_touch(order_t cur, way_t w);
    order_touch = (cur & keep_mask(w)) | set_mask(w);
  endfunction

  function automatic way_t order_oldest(order_t s);
    if (s[5:3] == 3'b111)                    order_oldest = 2'd0;
    else if (!s[5] && s[2] && s[1])          order_oldest = 2'd1;
    else if (!s[4] && !s[2] && s[0])         order_oldest = 2'd2;
    else                                     order_oldest = 2'd3;
  endfunction

endpackage

// File: rtl/itlb_lru_victim_sel.sv
`timescale 1ns/1ps
module itlb_lru_victim_sel
  import itlb_lru_pkg::*;
(
  input  order_t order_i,
  output way_t   victim_o
);
  always_comb victim_o = order_oldest(order_i);
endmodule

// File: rtl/itlb_lru_touch_unit.sv
`timescale 1ns/1ps
module itlb_lru_touch_unit
  import itlb_lru_pkg::*;
(
  input  order_t order_i,
  input  logic   touch_en_i,
  input  way_t   touch_idx_i,
  output order_t order_o
);
  order_t cand [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_comb cand[g] = order_touch(order_i, way_t'(g));
  end

  always_comb order_o = touch_en_i ? cand[touch_idx_i] : order_i;
endmodule

// File: rtl/itlb_lru_tracker.sv
`timescale 1ns/1ps
module itlb_lru_tracker
  import itlb_lru_pkg::*;
#(
  parameter int unsigned CTRL_W    = 32,
  parameter logic [31:0] RESET_VAL = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [CTRL_W-1:0] sw_data,
  input  logic              hit_vld,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              repl_req,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [IDX_W-1:0]  victim_idx
);
  localparam int unsigned ORD_LSB = CTRL_W - ORDER_W;

  order_t            order_cur;
  order_t            order_nxt;
  logic              touch_en;
  way_t              touch_idx;
  logic [CTRL_W-1:0] ctrl_d;

  assign order_cur = ctrl_q[ORD_LSB +: ORDER_W];

  itlb_lru_victim_sel u_victim (
    .order_i  (order_cur),
    .victim_o (victim_idx)
  );

  // Refill writes the victim, so it wins over a hit; software wins over both.
  assign touch_en  = !sw_wr && (repl_req || hit_vld);
  assign touch_idx = repl_req ? victim_idx : hit_idx;

  itlb_lru_touch_unit u_touch (
    .order_i     (order_cur),
    .touch_en_i  (touch_en),
    .touch_idx_i (touch_idx),
    .order_o     (order_nxt)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (sw_wr) ctrl_d = sw_data;
    else       ctrl_d[ORD_LSB +: ORDER_W] = order_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= RESET_VAL[CTRL_W-1:0];
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/itlb_lru_tracker_chk.sv
`timescale 1ns/1ps
module itlb_lru_tracker_chk #(
  parameter int unsigned CTRL_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_wr,
  input logic [CTRL_W-1:0] sw_data,
  input logic              hit_vld,
  input logic [1:0]        hit_idx,
  input logic              repl_req,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [1:0]        victim_idx,
  input logic              touch_en,
  input logic [1:0]        touch_idx
);
  localparam int unsigned LSB = CTRL_W - 6;

  p_sw_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> ctrl_q == $past(sw_data));

  p_hit0_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !repl_req && hit_vld && hit_idx == 2'd0) |=> ctrl_q[LSB+3 +: 3] == 3'b000);

  p_low_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ctrl_q[LSB-1:0] == $past(ctrl_q[LSB-1:0]));

  p_victim0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[LSB+3 +: 3] == 3'b111) |-> victim_idx == 2'd0);

  p_refill_pick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && repl_req) |-> (touch_en && touch_idx == victim_idx));

  p_touched_not_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && touch_idx != 2'd3) |=> victim_idx != $past(touch_idx));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr && !hit_vld && !repl_req) |=> $stable(ctrl_q));
endmodule

bind itlb_lru_tracker itlb_lru_tracker_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_wr      (sw_wr),
  .sw_data    (sw_data),
  .hit_vld    (hit_vld),
  .hit_idx    (hit_idx),
  .repl_req   (repl_req),
  .ctrl_q     (ctrl_q),
  .victim_idx (victim_idx),
  .touch_en   (touch_en),
  .touch_idx  (touch_idx)
);

// File: tb/itlb_lru_tracker_bench.sv
`timescale 1ns/1ps
module itlb_lru_tracker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_wr;
  logic [31:0] sw_data;
  logic        hit_vld;
  logic [1:0]  hit_idx;
  logic        repl_req;
  logic [31:0] ctrl_q;
  logic [1:0]  victim_idx;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  itlb_lru_tracker u_itlb_lru_tracker (
    .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_data(sw_data),
    .hit_vld(hit_vld), .hit_idx(hit_idx), .repl_req(repl_req),
    .ctrl_q(ctrl_q), .victim_idx(victim_idx)
  );

  // {hit_vld, hit_idx[1:0], repl_req, expected victim[1:0]} from reset order
  localparam logic [5:0] VEC [0:8] = '{
    6'b111010, 6'b110001, 6'b101000, 6'b000111, 6'b101011,
    6'b000110, 6'b000100, 6'b100001, 6'b111111
  };

  localparam logic [25:0] LOW = 26'h3A5_5A3C;

  // Recency model: rk[e]=0 newest, 3 oldest.
  int rk [4];

  function automatic logic [5:0] model_bits();
    model_bits = {rk[1] < rk[0], rk[2] < rk[0], rk[3] < rk[0],
                  rk[2] < rk[1], rk[3] < rk[1], rk[3] < rk[2]};
  endfunction

  function automatic logic [1:0] model_oldest();
    model_oldest = 2'd0;
    for (int e = 0; e < 4; e++) if (rk[e] == 3) model_oldest = 2'(e);
  endfunction

  task automatic model_touch(input int k);
    for (int e = 0; e < 4; e++) if (rk[e] < rk[k]) rk[e]++;
    rk[k] = 0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic sw, input logic [31:0] d, input logic hv,
                     input logic [1:0] hi, input logic rp);
    sw_wr = sw; sw_data = d; hit_vld = hv; hit_idx = hi; repl_req = rp;
    @(negedge clk);
    sw_wr = 1'b0; sw_data = '0; hit_vld = 1'b0; hit_idx = '0; repl_req = 1'b0;
  endtask

  task automatic mask_case(input string req, input logic [7:0] top,
                           input logic [1:0] w, input logic [7:0] exp_top);
    cyc(1'b1, {top, 24'h5AC3E1}, 1'b0, 2'd0, 1'b0);
    cyc(1'b0, '0, 1'b1, w, 1'b0);
    chk(req, ctrl_q, {exp_top, 24'h5AC3E1});
  endtask

  task automatic victim_case(input logic [31:0] v, input logic [1:0] exp);
    cyc(1'b1, v, 1'b0, 2'd0, 1'b0);
    chk("R8 victim", {30'd0, victim_idx}, {30'd0, exp});
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    string tag;
    rst_n = 1'b0; sw_wr = 1'b0; sw_data = '0; hit_vld = 1'b0; hit_idx = '0; repl_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", ctrl_q, 32'h0);
    chk("R1 reset victim", {30'd0, victim_idx}, 32'd3);
    rst_n = 1'b1;

    // Vector walk: low field set with order bits kept at the reset order.
    for (int e = 0; e < 4; e++) rk[e] = e;
    cyc(1'b1, {6'b000000, LOW}, 1'b0, 2'd0, 1'b0);
    chk("R2 load", ctrl_q, {6'b0, LOW});
    for (int i = 0; i < 9; i++) begin
      logic [5:0] v;
      v = VEC[i];
      if (v[2]) begin model_touch(int'(model_oldest())); tag = "R9"; end
      else begin
        model_touch(int'(v[4:3]));
        case (v[4:3])
          2'd0: tag = "R3"; 2'd1: tag = "R4"; 2'd2: tag = "R5"; default: tag = "R6";
        endcase
      end
      cyc(1'b0, '0, v[5], v[4:3], v[2]);
      chk({tag, " order"}, ctrl_q, {model_bits(), LOW});
      chk("R11 victim", {30'd0, victim_idx}, {30'd0, v[1:0]});
      chk("R7 low field", {6'd0, ctrl_q[25:0]}, {6'd0, LOW});
    end

    // R10: idle cycles hold the register
    held = ctrl_q;
    repeat (3) cyc(1'b0, '0, 1'b0, 2'd0, 1'b0);
    chk("R10 hold", ctrl_q, held);

    // R2: software write wins over a hit and a refill
    cyc(1'b1, 32'h1234_5678, 1'b1, 2'd2, 1'b1);
    chk("R2 priority", ctrl_q, 32'h1234_5678);

    // Exact mask effects from arbitrary starting values
    mask_case("R3 hit0", 8'hFF, 2'd0, 8'h1F);
    mask_case("R3 hit0", 8'hE3, 2'd0, 8'h03);
    mask_case("R4 hit1", 8'hFF, 2'd1, 8'hE7);
    mask_case("R4 hit1", 8'h00, 2'd1, 8'h80);
    mask_case("R5 hit2", 8'hFF, 2'd2, 8'hFB);
    mask_case("R5 hit2", 8'h00, 2'd2, 8'h50);
    mask_case("R6 hit3", 8'h00, 2'd3, 8'h2C);
    mask_case("R6 hit3", 8'hFF, 2'd3, 8'hFF);

    // Victim decode priority
    victim_case(32'hFC00_0000, 2'd0);
    victim_case(32'hE000_0000, 2'd0);
    victim_case(32'h1800_0000, 2'd1);
    victim_case(32'h1B12_3456, 2'd1);
    victim_case(32'h0400_0000, 2'd2);
    victim_case(32'h9800_0000, 2'd3);
    victim_case(32'h1400_0000, 2'd3);

    // R9: refill from a loaded state touches the decoded victim (2)
    cyc(1'b1, 32'h0400_00AA, 1'b0, 2'd0, 1'b0);
    cyc(1'b0, '0, 1'b1, 2'd0, 1'b1);
    chk("R9 refill", ctrl_q, 32'h5000_00AA);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule